// File: doc/BRIEF.md
# Compare Timer Channel with Count Offset

This block is one timer channel belonging to a single core. It watches a free-running 64-bit system count that is shared across the chip. When that count reaches a 64-bit deadline programmed by software, the channel raises a level interrupt. The count the channel sees can be shifted down by a 64-bit offset register. With the offset the channel acts as a virtual timer, so a guest sees the count minus the offset. A counter-on flag arrives with the shared count. While the flag is low, the count is treated as stopped and the channel sees zero.

Software programs the deadline in one of two ways. It can write an absolute 64-bit compare value in two halves. It can also write a relative 32-bit timer value, which is added to the current count. Reading the timer value returns the signed distance to the deadline, truncated to 32 bits. A control word holds an enable bit, a mask bit and a read-only status flag. The interrupt output is registered and re-evaluated on every clock.

Top module: `cmp_timer_channel`

## Requirements
- R1: A synchronous active-low reset clears enable, mask, compare value, offset and the `irq` output to zero.
- R2: Register address 0 writes and reads compare bits 31:0, and address 1 writes and reads compare bits 63:32.
- R3: Address 3 is the control word: bit 0 is enable, bit 1 is mask, and bit 2 is status. Status reads 1 exactly when enable is 1 and the seen count is at or above the compare value, compared as unsigned 64-bit numbers.
- R4: `irq` is a register that takes enable AND status AND NOT mask, evaluated one clock earlier.
- R5: With mask set, `irq` stays 0, while status still reads back as 1 when the deadline has passed.
- R6: A write to bit 2 of the control word has no effect on the status flag.
- R7: Reading address 2 returns the compare value minus the seen count, bits 31:0.
- R8: Writing address 2 sets the compare value to the seen count plus the written 32-bit value sign-extended to 64 bits.
- R9: Addresses 4 and 5 hold offset bits 31:0 and 63:32. With the offset enabled, the seen count is the system count minus the offset, modulo 2^64.
- R10: While `count_on` is 0, the seen count is zero.
- R11: The deadline comparison uses the upper word of both the count and the compare value: a count of 0xFFFFFFFF does not reach a compare value of 0x1_00000000, and a count of 0x1_00000000 does.
- R12: Unused addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_count | input | CNT_W | Shared free-running system count |
| count_on | input | 1 | System counter running; when 0 the seen count is zero |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Level timer interrupt |

## Verification
The bench builds the channel with the default 64-bit count, 32-bit register words and the offset register present. This brings the virtual-timer subtraction, the carries across the upper word, and sign extension of negative timer values within reach. A behavioural model with 64-bit integers predicts `irq` and the read data on every clock. Directed reads with hand-computed values cover these cases:
- a deadline that has already passed;
- a masked deadline;
- a stopped counter;
- a deadline that lies just across the 32-bit boundary.

// File: rtl/cmp_timer_pkg.sv
// Shared definitions for the compare timer channel.
// Assumes a 3-bit register select and control bit positions fixed here.
package cmp_timer_pkg;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_CMP_LO = 3'd0,
        RA_CMP_HI = 3'd1,
        RA_TVAL   = 3'd2,
        RA_CTRL   = 3'd3,
        RA_OFF_LO = 3'd4,
        RA_OFF_HI = 3'd5
    } reg_addr_e;

    localparam int CTL_EN   = 0;
    localparam int CTL_MASK = 1;
    localparam int CTL_STAT = 2;
endpackage

// File: rtl/cmp_count_view.sv
// Produces the count seen by the channel: zero while the system counter is
// off, otherwise the system count minus the offset (modulo 2^CNT_W).
// Assumes the offset is already zero when the offset variant is not built.
module cmp_count_view #(
    parameter int CNT_W = 64
) (
    input  logic [CNT_W-1:0] sys_count,
    input  logic             count_on,
    input  logic [CNT_W-1:0] offset,
    output logic [CNT_W-1:0] view
);
    // Select the adjusted count or zero.
    always_comb begin
        view = count_on ? (sys_count - offset) : '0;
    end

    // Adding the offset back must recover the raw count.
    always_comb begin
        if (count_on) begin
            assert_view_offset_R9: assert (view + offset == sys_count);
        end
    end
endmodule

// File: rtl/cmp_regs.sv
// Holds control bits, the 64-bit compare value and the optional offset.
// Assumes CNT_W is twice DATA_W and TV_W is at most DATA_W; writes take
// effect on the next clock.
module cmp_regs
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W     = 64,
    parameter int DATA_W    = 32,
    parameter int TV_W      = 32,
    parameter bit OFFSET_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  view,
    output logic              ctl_en,
    output logic              ctl_mask,
    output logic [CNT_W-1:0]  cmp_val,
    output logic [CNT_W-1:0]  off_val
);
    localparam int EXT_W = CNT_W - TV_W;

    logic [CNT_W-1:0] tval_ext;
    logic             wr_cmp_lo;
    logic             wr_cmp_hi;
    logic             wr_tval;
    logic             wr_ctrl;
    logic             wr_off_lo;
    logic             wr_off_hi;

    // Decode write strobes per register.
    always_comb begin
        wr_cmp_lo = wr_en && (addr == RA_CMP_LO);
        wr_cmp_hi = wr_en && (addr == RA_CMP_HI);
        wr_tval   = wr_en && (addr == RA_TVAL);
        wr_ctrl   = wr_en && (addr == RA_CTRL);
        wr_off_lo = wr_en && (addr == RA_OFF_LO);
        wr_off_hi = wr_en && (addr == RA_OFF_HI);
    end

    // Sign-extend the relative timer value to the count width.
    always_comb begin
        tval_ext = {{EXT_W{wdata[TV_W-1]}}, wdata[TV_W-1:0]};
    end

    // Control bits; the status position is not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en   <= 1'b0;
            ctl_mask <= 1'b0;
        end else if (wr_ctrl) begin
            ctl_en   <= wdata[CTL_EN];
            ctl_mask <= wdata[CTL_MASK];
        end
    end

    // Compare value: absolute halves or relative to the seen count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_val <= '0;
        end else if (wr_tval) begin
            cmp_val <= view + tval_ext;
        end else if (wr_cmp_lo) begin
            cmp_val[DATA_W-1:0] <= wdata;
        end else if (wr_cmp_hi) begin
            cmp_val[CNT_W-1:DATA_W] <= wdata;
        end
    end

    generate
        if (OFFSET_EN) begin : g_offset
            // Offset register for the virtual-timer variant.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    off_val <= '0;
                end else if (wr_off_lo) begin
                    off_val[DATA_W-1:0] <= wdata;
                end else if (wr_off_hi) begin
                    off_val[CNT_W-1:DATA_W] <= wdata;
                end
            end
        end else begin : g_no_offset
            // Physical variant: the count is used unshifted.
            always_comb begin
                off_val = '0;
            end
        end
    endgenerate

    assert_ctrl_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (ctl_en == $past(wdata[CTL_EN])) && (ctl_mask == $past(wdata[CTL_MASK])));

    assert_tval_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tval |=> (cmp_val - $past(view)) == $past(tval_ext));
endmodule

// File: rtl/cmp_deadline.sv
// Compares the seen count with the deadline and registers the interrupt.
// Assumes an unsigned compare; status is combinational, irq lags by a clock.
module cmp_deadline #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             mask,
    input  logic [CNT_W-1:0] view,
    input  logic [CNT_W-1:0] cmp_val,
    output logic             status,
    output logic             irq
);
    // The deadline is met while enabled and the count is at or past it.
    always_comb begin
        status = en && (view >= cmp_val);
    end

    // Registered level interrupt, re-evaluated each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= en && status && !mask;
        end
    end

    assert_irq_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !mask) |=> irq);

    assert_mask_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mask |=> !irq);

    assert_status_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !status);
endmodule

// File: rtl/cmp_timer_channel.sv
// One per-core compare timer channel. It offsets the shared count, holds
// the deadline registers, raises a level interrupt and serves reads.
// Assumes reads are combinational and writes land on the next clock.
module cmp_timer_channel
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W     = 64,
    parameter int DATA_W    = 32,
    parameter int TV_W      = 32,
    parameter bit OFFSET_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  sys_count,
    input  logic              count_on,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic [CNT_W-1:0] view;
    logic [CNT_W-1:0] cmp_val;
    logic [CNT_W-1:0] off_val;
    logic             ctl_en;
    logic             ctl_mask;
    logic             status;
    logic [TV_W-1:0]  tval_rd;

    cmp_count_view #(.CNT_W(CNT_W)) u_view (
        .sys_count (sys_count),
        .count_on  (count_on),
        .offset    (off_val),
        .view      (view)
    );

    cmp_regs #(
        .CNT_W     (CNT_W),
        .DATA_W    (DATA_W),
        .TV_W      (TV_W),
        .OFFSET_EN (OFFSET_EN)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .view     (view),
        .ctl_en   (ctl_en),
        .ctl_mask (ctl_mask),
        .cmp_val  (cmp_val),
        .off_val  (off_val)
    );

    cmp_deadline #(.CNT_W(CNT_W)) u_deadline (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctl_en),
        .mask    (ctl_mask),
        .view    (view),
        .cmp_val (cmp_val),
        .status  (status),
        .irq     (irq)
    );

    // Relative view: distance to the deadline, low word only.
    always_comb begin
        tval_rd = cmp_val[TV_W-1:0] - view[TV_W-1:0];
    end

    // Read multiplexer over the register map.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CMP_LO: reg_rdata = cmp_val[DATA_W-1:0];
            RA_CMP_HI: reg_rdata = cmp_val[CNT_W-1:DATA_W];
            RA_TVAL:   reg_rdata[TV_W-1:0] = tval_rd;
            RA_CTRL: begin
                reg_rdata[CTL_EN]   = ctl_en;
                reg_rdata[CTL_MASK] = ctl_mask;
                reg_rdata[CTL_STAT] = status;
            end
            RA_OFF_LO: reg_rdata = off_val[DATA_W-1:0];
            RA_OFF_HI: reg_rdata = off_val[CNT_W-1:DATA_W];
            default:   reg_rdata = '0;
        endcase
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq && !ctl_en && !ctl_mask && cmp_val == '0 && off_val == '0));

    assert_stopped_view_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_on && reg_addr == RA_TVAL) |-> reg_rdata[TV_W-1:0] == cmp_val[TV_W-1:0]);
endmodule

// File: tb/cmp_timer_channel_test.sv
module cmp_timer_channel_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_count = '0;
    logic        count_on = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Reference model state
    logic [63:0] m_cmp = '0;
    logic [63:0] m_off = '0;
    logic        m_en = 1'b0;
    logic        m_mask = 1'b0;
    logic        m_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_timer_channel uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sys_count (sys_count),
        .count_on  (count_on),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    function automatic logic [63:0] m_view();
        return count_on ? (sys_count - m_off) : 64'd0;
    endfunction

    function automatic logic m_status();
        return m_en && (m_view() >= m_cmp);
    endfunction

    function automatic logic [31:0] m_read();
        logic [63:0] d;
        case (reg_addr)
            3'd0: return m_cmp[31:0];
            3'd1: return m_cmp[63:32];
            3'd2: begin d = m_cmp - m_view(); return d[31:0]; end
            3'd3: return {29'd0, m_status(), m_mask, m_en};
            3'd4: return m_off[31:0];
            3'd5: return m_off[63:32];
            default: return 32'd0;
        endcase
    endfunction

    function automatic string rd_tag();
        case (reg_addr)
            3'd0, 3'd1: return "R2";
            3'd2:       return "R7";
            3'd3:       return "R3";
            3'd4, 3'd5: return "R9";
            default:    return "R12";
        endcase
    endfunction

    // Model update on each rising edge, using pre-edge state.
    always @(posedge clk) begin
        logic nxt_irq;
        logic [63:0] ext;
        if (!rst_n) begin
            m_cmp = '0; m_off = '0; m_en = 1'b0; m_mask = 1'b0; m_irq = 1'b0;
        end else begin
            nxt_irq = m_en && m_status() && !m_mask;
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: m_cmp[31:0] = reg_wdata;
                    3'd1: m_cmp[63:32] = reg_wdata;
                    3'd2: begin
                        ext = {{32{reg_wdata[31]}}, reg_wdata};
                        m_cmp = m_view() + ext;
                    end
                    3'd3: begin m_en = reg_wdata[0]; m_mask = reg_wdata[1]; end
                    3'd4: m_off[31:0] = reg_wdata;
                    3'd5: m_off[63:32] = reg_wdata;
                    default: ;
                endcase
            end
            m_irq = nxt_irq;
        end
    end

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (!done) begin
            total++;
            if (irq !== m_irq) begin
                bad++;
                $display("FAIL R4 irq actual=%0b expected=%0b", irq, m_irq);
            end
            total++;
            if (reg_rdata !== m_read()) begin
                bad++;
                $display("FAIL %s rdata addr=%0d actual=%h expected=%h",
                         rd_tag(), reg_addr, reg_rdata, m_read());
            end
        end
    end

    task automatic drive(input logic wr, input logic [2:0] a, input logic [31:0] d,
                         input logic [63:0] c, input logic on);
        @(posedge clk);
        #1;
        reg_wr = wr; reg_addr = a; reg_wdata = d; sys_count = c; count_on = on;
    endtask

    // Read a register at a given count and compare with a hand value.
    task automatic expect_rd(input string tag, input logic [2:0] a, input logic [63:0] c,
                             input logic on, input logic [31:0] exp);
        drive(1'b0, a, 32'd0, c, on);
        @(negedge clk);
        #1;
        total++;
        if (reg_rdata !== exp) begin
            bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic expect_irq(input string tag, input logic exp);
        @(negedge clk);
        #1;
        total++;
        if (irq !== exp) begin
            bad++;
            $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, exp);
        end
    endtask

    initial begin
        repeat (3) drive(1'b0, 3'd3, 32'd0, 64'd7, 1'b1);
        expect_rd("R1", 3'd3, 64'd7, 1'b1, 32'd0);
        expect_irq("R1", 1'b0);
        rst_n = 1'b1;
        expect_rd("R1", 3'd0, 64'd7, 1'b1, 32'd0);
        expect_rd("R12", 3'd6, 64'd7, 1'b1, 32'd0);

        // Deadline at 100, enable, ramp the count.
        drive(1'b1, 3'd0, 32'd100, 64'd50, 1'b1);
        drive(1'b1, 3'd1, 32'd0, 64'd51, 1'b1);
        drive(1'b1, 3'd3, 32'd1, 64'd52, 1'b1);
        expect_rd("R2", 3'd0, 64'd53, 1'b1, 32'd100);
        expect_rd("R3", 3'd3, 64'd99, 1'b1, 32'd1);
        expect_rd("R3", 3'd3, 64'd100, 1'b1, 32'd5);
        drive(1'b0, 3'd3, 32'd0, 64'd101, 1'b1);
        expect_irq("R4", 1'b1);
        for (int i = 0; i < 10; i++) drive(1'b0, 3'(i % 8), 32'd0, 64'd102 + 64'(i), 1'b1);

        // Mask keeps irq low but status visible.
        drive(1'b1, 3'd3, 32'd3, 64'd120, 1'b1);
        expect_rd("R5", 3'd3, 64'd121, 1'b1, 32'd7);
        drive(1'b0, 3'd3, 32'd0, 64'd122, 1'b1);
        expect_irq("R5", 1'b0);

        // Status bit writes ignored.
        drive(1'b1, 3'd3, 32'd4, 64'd123, 1'b1);
        expect_rd("R6", 3'd3, 64'd124, 1'b1, 32'd0);
        drive(1'b1, 3'd3, 32'd5, 64'd50, 1'b1);
        expect_rd("R6", 3'd3, 64'd50, 1'b1, 32'd1);

        // Relative reads, positive and past the deadline.
        expect_rd("R7", 3'd2, 64'd60, 1'b1, 32'd40);
        expect_rd("R7", 3'd2, 64'd110, 1'b1, 32'hFFFF_FFF6);

        // Relative writes, positive and negative.
        drive(1'b1, 3'd2, 32'd50, 64'd1000, 1'b1);
        expect_rd("R8", 3'd0, 64'd1001, 1'b1, 32'd1050);
        drive(1'b1, 3'd2, 32'hFFFF_FFF0, 64'd1000, 1'b1);
        expect_rd("R8", 3'd0, 64'd1001, 1'b1, 32'd984);
        expect_rd("R8", 3'd1, 64'd1002, 1'b1, 32'd0);
        expect_rd("R8", 3'd3, 64'd1003, 1'b1, 32'd5);

        // Offset shifts the seen count.
        drive(1'b1, 3'd4, 32'h1000, 64'h1100, 1'b1);
        drive(1'b1, 3'd5, 32'd0, 64'h1100, 1'b1);
        expect_rd("R9", 3'd2, 64'h1100, 1'b1, 32'h2D8);
        expect_rd("R9", 3'd4, 64'h1100, 1'b1, 32'h1000);
        expect_rd("R9", 3'd3, 64'h1100, 1'b1, 32'd1);

        // Stopped counter: seen count is zero.
        expect_rd("R10", 3'd2, 64'h9999, 1'b0, 32'd984);
        expect_rd("R10", 3'd3, 64'h9999, 1'b0, 32'd1);

        // Upper-word comparison.
        drive(1'b1, 3'd4, 32'd0, 64'd0, 1'b1);
        drive(1'b1, 3'd0, 32'd0, 64'd0, 1'b1);
        drive(1'b1, 3'd1, 32'd1, 64'd0, 1'b1);
        expect_rd("R11", 3'd3, 64'h0000_0000_FFFF_FFFF, 1'b1, 32'd1);
        expect_rd("R11", 3'd3, 64'h0000_0001_0000_0000, 1'b1, 32'd5);
        drive(1'b0, 3'd3, 32'd0, 64'h0000_0001_0000_0001, 1'b1);
        expect_irq("R11", 1'b1);

        // Reset again while active clears everything.
        rst_n = 1'b0;
        drive(1'b0, 3'd1, 32'd0, 64'h0000_0001_0000_0002, 1'b1);
        drive(1'b0, 3'd1, 32'd0, 64'h0000_0001_0000_0003, 1'b1);
        rst_n = 1'b1;
        expect_rd("R1", 3'd1, 64'h0000_0001_0000_0004, 1'b1, 32'd0);
        expect_irq("R1", 1'b0);

        drive(1'b0, 3'd0, 32'd0, 64'd0, 1'b1);
        @(posedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule